// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block holds the software-visible settings of one clock root generator and presents a stable copy of them to the divider and source-select logic. Software writes the divider, source select, mode and the three fractional registers into shadow copies through a simple single-cycle read/write port. The values the datapath sees change only when software sets the update bit in the command register. When it does, every shadow value moves into the active copy on a single clock edge.

A small commit state machine models the delay of handing the new settings to the output clock domain. It has three states. In IDLE it waits. A write of 1 to the update bit takes it to SYNC. SYNC counts down `SYNC_CYC-1` edges and then moves to APPLY. APPLY copies the shadows to the active set, clears the dirty flags and returns to IDLE. The update bit reads 1 in every state except IDLE.

The root enable in the command register acts at once. The top status bit reports that the root is off, so software sees the clock as running exactly when that bit reads 0.

Top module: `clkgen_cfg_regs`

## Requirements
- R1: After reset the command register reads 0x00000002 (root enabled, no update pending, no dirty flag, root-off status 0). Configuration, M, N and D read 0, and every active output is 0 except `root_en_o`, which is 1.
- R2: A write to the configuration register (0x4) or to M (0x8), N (0xC) or D (0x10) changes the value read back at once. It leaves the active outputs unchanged until a commit completes.
- R3: A write with bit 0 set to the command register (0x0) sets the update bit. The bit reads 1 for `SYNC_CYC` cycles after the write edge. On the edge where it returns to 0, all active outputs take the shadow values together.
- R4: Command bits 4, 5, 6 and 7 are dirty flags for configuration, N, M and D respectively. Each is set by a write to its register and cleared when a commit completes. Writes to these bits have no effect.
- R5: A write of 1 to the update bit while a commit is pending does not restart or extend it. A write of 0 to the update bit starts no commit.
- R6: Command bit 1 drives `root_en_o` from the edge after the write, without waiting for a commit. Command bit 31 reads 1 exactly when the root enable is 0, and writes to bit 31 have no effect.
- R7: The configuration register holds the pre-divider in bits HID_W-1:0, the source select in bits 10:8 and the mode in bits 13:12. M, N and D keep only their low MND_W bits. All other bits read 0.
- R8: Writes to an unmapped offset change no register, and reads from an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Access select |
| penable | input | 1 | Access strobe; a write lands when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| root_en_o | output | 1 | Root clock enable |
| pre_div_o | output | HID_W | Active pre-divider |
| src_sel_o | output | 3 | Active source select index |
| mode_o | output | 2 | Active counter mode |
| m_o | output | MND_W | Active M value |
| n_o | output | MND_W | Active N value |
| d_o | output | MND_W | Active D value |

## Verification
Read data is combinational, so a value written on one edge is checked on the falling edge that follows it. Dirty flags and shadow read-back are due in that same half cycle. For a commit the write edge counts as edge 0. The bench samples the update bit on each falling edge after edges 0 to SYNC_CYC-1 and expects 1. After edge SYNC_CYC it expects the update bit to be 0, the active outputs to hold the model's shadow values and the dirty flags to be clear. A second update write placed two edges into a commit tests that the completion edge does not move.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;
    localparam logic [4:0] OFS_CMD = 5'h00;
    localparam logic [4:0] OFS_CFG = 5'h04;
    localparam logic [4:0] OFS_M   = 5'h08;
    localparam logic [4:0] OFS_N   = 5'h0C;
    localparam logic [4:0] OFS_D   = 5'h10;

    // dirty vector index -> command bit (index + 4)
    localparam int DIDX_CFG = 0;
    localparam int DIDX_N   = 1;
    localparam int DIDX_M   = 2;
    localparam int DIDX_D   = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_APPLY = 2'd2
    } commit_st_e;

    function automatic logic [4:0] mnd_offset(input int idx);
        case (idx)
            DIDX_N:  mnd_offset = OFS_N;
            DIDX_M:  mnd_offset = OFS_M;
            default: mnd_offset = OFS_D;
        endcase
    endfunction
endpackage

// File: rtl/cgc_commit_fsm.sv
module cgc_commit_fsm
    import clkgen_cfg_pkg::*;
#(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o,
    output logic apply_o
);
    localparam int CNT_W = (SYNC_CYC > 2) ? $clog2(SYNC_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC - 1);

    commit_st_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) begin
                    state_d = ST_SYNC;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_SYNC: begin
                if (cnt_q <= CNT_W'(1)) state_d = ST_APPLY;
                else                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        apply_o = (state_q == ST_APPLY);
    end

    // R3: the update bit only rises after a request
    assert_upd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i));
    // R3: a hand-off always ends the pending period
    assert_apply_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !busy_o);
    // R5: a request while pending never re-enters the count from the top
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !apply_o && go_i) |=> busy_o);
endmodule

// File: rtl/cgc_field_reg.sv
module cgc_field_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic         apply_i,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] active_o,
    output logic         dirty_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_o <= '0;
            active_o <= '0;
            dirty_o  <= 1'b0;
        end else begin
            if (apply_i) active_o <= shadow_o;
            if (wr_en_i) shadow_o <= wdata_i;
            if (wr_en_i)      dirty_o <= 1'b1;
            else if (apply_i) dirty_o <= 1'b0;
        end
    end

    // R4: a write always leaves the flag set
    assert_dirty_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> dirty_o);
    // R2: the active copy moves only on a hand-off
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(active_o));
endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
    import clkgen_cfg_pkg::*;
#(
    parameter int HID_W    = 5,
    parameter int MND_W    = 8,
    parameter int SYNC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [4:0]       paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    output logic             root_en_o,
    output logic [HID_W-1:0] pre_div_o,
    output logic [2:0]       src_sel_o,
    output logic [1:0]       mode_o,
    output logic [MND_W-1:0] m_o,
    output logic [MND_W-1:0] n_o,
    output logic [MND_W-1:0] d_o
);
    localparam int CFG_W = HID_W + 5;   // {mode, src, pre_div}
    localparam int NFLD  = 4;

    logic wr_acc, cmd_wr, go, busy, apply;
    logic root_en_q;
    logic [NFLD-1:0] dirty;
    logic [CFG_W-1:0] cfg_sh, cfg_act, cfg_wd;
    logic [MND_W-1:0] mnd_sh  [1:NFLD-1];
    logic [MND_W-1:0] mnd_act [1:NFLD-1];

    assign wr_acc = psel && penable && pwrite;
    assign cmd_wr = wr_acc && (paddr == OFS_CMD);
    assign go     = cmd_wr && pwdata[0];
    assign cfg_wd = {pwdata[13:12], pwdata[10:8], pwdata[HID_W-1:0]};

    cgc_commit_fsm #(.SYNC_CYC(SYNC_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_i(go), .busy_o(busy), .apply_o(apply)
    );

    cgc_field_reg #(.W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_acc && (paddr == OFS_CFG)), .wdata_i(cfg_wd),
        .apply_i(apply), .shadow_o(cfg_sh), .active_o(cfg_act),
        .dirty_o(dirty[DIDX_CFG])
    );

    for (genvar i = 1; i < NFLD; i++) begin : g_mnd
        cgc_field_reg #(.W(MND_W)) u_fld (
            .clk(clk), .rst_n(rst_n),
            .wr_en_i(wr_acc && (paddr == mnd_offset(i))),
            .wdata_i(pwdata[MND_W-1:0]),
            .apply_i(apply), .shadow_o(mnd_sh[i]), .active_o(mnd_act[i]),
            .dirty_o(dirty[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      root_en_q <= 1'b1;
        else if (cmd_wr) root_en_q <= pwdata[1];
    end

    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_CMD: begin
                prdata[31]  = ~root_en_q;
                prdata[7:4] = dirty;
                prdata[1]   = root_en_q;
                prdata[0]   = busy;
            end
            OFS_CFG: begin
                prdata[13:12]     = cfg_sh[CFG_W-1 -: 2];
                prdata[10:8]      = cfg_sh[HID_W +: 3];
                prdata[HID_W-1:0] = cfg_sh[HID_W-1:0];
            end
            OFS_N:   prdata[MND_W-1:0] = mnd_sh[DIDX_N];
            OFS_M:   prdata[MND_W-1:0] = mnd_sh[DIDX_M];
            OFS_D:   prdata[MND_W-1:0] = mnd_sh[DIDX_D];
            default: prdata = '0;
        endcase
    end

    assign root_en_o = root_en_q;
    assign pre_div_o = cfg_act[HID_W-1:0];
    assign src_sel_o = cfg_act[HID_W +: 3];
    assign mode_o    = cfg_act[CFG_W-1 -: 2];
    assign n_o       = mnd_act[DIDX_N];
    assign m_o       = mnd_act[DIDX_M];
    assign d_o       = mnd_act[DIDX_D];

    // R4: a hand-off with no coincident write leaves no flag set
    assert_dirty_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !wr_acc) |=> (dirty == '0));
    // R7: reserved command bits never read as 1
    assert_cmd_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (paddr == OFS_CMD) |-> (prdata[30:8] == '0 && prdata[3:2] == '0));
    // R6: status bit opposes the enable output
    assert_root_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (paddr == OFS_CMD) |-> (prdata[31] == !root_en_o));
endmodule

// File: tb/clkgen_cfg_regs_bench.sv
module clkgen_cfg_regs_bench;
    localparam int HID_W = 5, MND_W = 8, SYNC_CYC = 4;
    localparam logic [31:0] CFG_MASK = ((32'd1 << HID_W) - 1) | 32'h0000_3700;
    localparam logic [31:0] MND_MASK = (32'd1 << MND_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [4:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic root_en_o;
    logic [HID_W-1:0] pre_div_o;
    logic [2:0] src_sel_o;
    logic [1:0] mode_o;
    logic [MND_W-1:0] m_o, n_o, d_o;

    int checks = 0, errors = 0;
    // model: shadows, actives, dirty {D,M,N,CFG}, root enable
    logic [31:0] sh_cfg, sh_m, sh_n, sh_d, ac_cfg, ac_m, ac_n, ac_d;
    logic [3:0] mdirty;
    logic mroot;

    clkgen_cfg_regs #(.HID_W(HID_W), .MND_W(MND_W), .SYNC_CYC(SYNC_CYC)) u_clkgen_cfg_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .root_en_o(root_en_o),
        .pre_div_o(pre_div_o), .src_sel_o(src_sel_o), .mode_o(mode_o),
        .m_o(m_o), .n_o(n_o), .d_o(d_o)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_cmd(input logic upd);
        return {~mroot, 23'd0, mdirty, 2'b00, mroot, upd};
    endfunction

    function automatic logic [31:0] act_cfg();
        return {18'd0, mode_o, 1'b0, src_sel_o, 3'd0, pre_div_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        case (a)
            5'h00: mroot = d[1];
            5'h04: begin sh_cfg = d & CFG_MASK; mdirty[0] = 1; end
            5'h0C: begin sh_n = d & MND_MASK; mdirty[1] = 1; end
            5'h08: begin sh_m = d & MND_MASK; mdirty[2] = 1; end
            5'h10: begin sh_d = d & MND_MASK; mdirty[3] = 1; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        psel = 1; pwrite = 0; paddr = a;
        #1 d = prdata;
        psel = 0;
    endtask

    task automatic chk_active(input string req);
        chk(req, act_cfg(), ac_cfg);
        chk(req, {24'd0, m_o}, ac_m);
        chk(req, {24'd0, n_o}, ac_n);
        chk(req, {24'd0, d_o}, ac_d);
    endtask

    task automatic commit_and_check();
        logic [31:0] r;
        wr(5'h00, {30'd0, mroot, 1'b1});
        for (int k = 0; k < SYNC_CYC; k++) begin
            rd(5'h00, r);
            chk("R3 update pending", r, exp_cmd(1'b1));
            chk_active("R2 active held during commit");
            @(negedge clk);
        end
        ac_cfg = sh_cfg; ac_m = sh_m; ac_n = sh_n; ac_d = sh_d; mdirty = '0;
        rd(5'h00, r);
        chk("R3/R4 commit done", r, exp_cmd(1'b0));
        chk_active("R3 active after commit");
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        sh_cfg = 0; sh_m = 0; sh_n = 0; sh_d = 0;
        ac_cfg = 0; ac_m = 0; ac_n = 0; ac_d = 0; mdirty = 0; mroot = 1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, r); chk("R1 cmd reset", r, 32'h0000_0002);
        rd(5'h04, r); chk("R1 cfg reset", r, 0);
        rd(5'h08, r); chk("R1 m reset", r, 0);
        chk("R1 root_en", {31'd0, root_en_o}, 1);
        chk_active("R1 active reset");

        // R2/R7 shadow write and field layout
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, r); chk("R7 cfg layout", r, CFG_MASK);
        wr(5'h0C, 32'hABCD_1234);
        rd(5'h0C, r); chk("R7 n masked", r, 32'h34);
        rd(5'h00, r); chk("R4 dirty cfg+N", r, exp_cmd(1'b0));
        chk_active("R2 no early effect");
        commit_and_check();

        // R5 second request mid-commit does not extend
        wr(5'h08, 32'h5A);
        wr(5'h00, 32'h3);
        @(negedge clk);
        wr(5'h00, 32'h3);
        rd(5'h00, r); chk("R5 still pending", r[0], 1);
        @(negedge clk);
        rd(5'h00, r); chk("R5 still pending", r[0], 1);
        @(negedge clk);
        ac_m = sh_m; mdirty = 0;
        rd(5'h00, r); chk("R5 not extended", r, exp_cmd(1'b0));
        chk_active("R5 applied on time");

        // R5 writing 0 to update starts nothing
        wr(5'h10, 32'h77);
        wr(5'h00, 32'h2);
        repeat (SYNC_CYC + 2) @(negedge clk);
        rd(5'h00, r); chk("R5 zero write no commit", r, exp_cmd(1'b0));
        chk_active("R5 active unchanged");

        // R6 root enable immediate, status bit, bit31 write ignored
        wr(5'h00, 32'h8000_0000);
        chk("R6 root_en off", {31'd0, root_en_o}, 0);
        rd(5'h00, r); chk("R6 root-off status", r, exp_cmd(1'b0));
        wr(5'h00, 32'h0000_0002);
        rd(5'h00, r); chk("R6 root-on status", r, exp_cmd(1'b0));
        // R4 dirty bits not writable
        wr(5'h00, 32'h0000_00F2);
        rd(5'h00, r); chk("R4 dirty write ignored", r, exp_cmd(1'b0));

        // R8 unmapped offsets
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14, r); chk("R8 unmapped read", r, 0);
        rd(5'h00, r); chk("R8 unmapped write no dirty", r, exp_cmd(1'b0));
        rd(5'h04, r); chk("R8 cfg intact", r, sh_cfg);
        commit_and_check();

        // random rounds
        for (int it = 0; it < 30; it++) begin
            for (int f = 0; f < 4; f++) begin
                if ($urandom_range(1, 0) == 1) begin
                    case (f)
                        0: wr(5'h04, $urandom());
                        1: wr(5'h0C, $urandom());
                        2: wr(5'h08, $urandom());
                        default: wr(5'h10, $urandom());
                    endcase
                end
            end
            rd(5'h00, r); chk("R4 random dirty", r, exp_cmd(1'b0));
            rd(5'h04, r); chk("R2 random cfg readback", r, sh_cfg);
            rd(5'h10, r); chk("R2 random d readback", r, sh_d);
            chk_active("R2 random held");
            commit_and_check();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule